// File: doc/BRIEF.md
# Three-wire control word receiver

This block takes the serial programming word of a frequency synthesizer from a three-line bus (data, clock, enable) and keeps the last accepted word in output registers. All three bus lines are sampled by a system clock that runs much faster than the bus. Data bits are collected only while the enable line is high, one bit on each falling edge of the bus clock. When enable drops, the collected word goes to the outputs only if exactly eighteen bus clock falling edges were seen in that enable window. Any other count discards the word.

An accepted word splits into a 14-bit divider ratio and four switch bits. A flag marks a divider ratio of zero, which turns the synthesizer loop off. In this bus mode the reference divider setting is fixed at 512 and the charge pump always uses its high current, so both are driven as constants. A one-cycle pulse marks each accepted word.

Top module: `tw_ctrl_rx`

## Requirements
- R1: After reset, `div_ratio_o`, `switch_o` and `word_valid_o` are zero, and `pll_disable_o` is one because the divider ratio is zero.
- R2: When enable falls after exactly 18 bus clock falling edges in its high period, the bits go to the outputs most significant first. The first 14 bits received give `div_ratio_o[13:0]` in order from bit 13 to bit 0, and the last 4 give `switch_o[3:0]` in order from bit 3 to bit 0.
- R3: When enable falls after fewer than 18 bus clock falling edges, the outputs keep their earlier values and `word_valid_o` stays low.
- R4: When enable falls after more than 18 bus clock falling edges, the word is discarded. This includes bursts far longer than 18, such as 50. The edge counter saturates, so it never wraps back to 18.
- R5: Bus clock falling edges while enable is low neither shift data nor advance the count. A correct 18-bit frame after such edges is still accepted unchanged.
- R6: The edge count restarts at zero on every rising edge of enable. A short discarded frame has no effect on the frame that follows it.
- R7: `pll_disable_o` is 1 exactly when the held divider ratio is zero.
- R8: `word_valid_o` is a one-cycle pulse for each accepted word. It is high in the cycle that follows the third rising system clock edge at which the low enable level is sampled, together with the new output values.
- R9: `ref_div_o` is always 512 and `cp_high_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Serial data line |
| scl_i | input | 1 | Serial clock line |
| ena_i | input | 1 | Enable (frame) line |
| div_ratio_o | output | 14 | Held programmable divider ratio |
| switch_o | output | 4 | Held switch bits |
| pll_disable_o | output | 1 | High when the held divider ratio is zero |
| word_valid_o | output | 1 | One-cycle pulse when a new word is taken |
| ref_div_o | output | 10 | Fixed reference divider ratio (512) |
| cp_high_o | output | 1 | Charge pump high-current select, tied high |

## Verification
Faults in the edge counter or the shift register stay hidden until enable falls. At that point a wrong count either drops a legal word or accepts an illegal one, and a wrong shift gives a wrong divider or switch value. The error shows on the third system clock edge after the enable fall is sampled. A reference model in the bench follows every cycle, so a difference shows at the first cycle where the ports disagree. Directed frames of 10, 17, 18, 19 and 50 edges, bus clock edges while enable is low, and a zero divider cover the count limits and the disable flag.

// File: rtl/tw_ctrl_pkg.sv
`timescale 1ns/1ps
package tw_ctrl_pkg;
  localparam int unsigned TW_DIV_W       = 14;
  localparam int unsigned TW_SW_W        = 4;
  localparam int unsigned TW_REF_DIV_W   = 10;
  localparam int unsigned TW_REF_DIV_VAL = 512;
  localparam int unsigned TW_NUM_LINES   = 3;

  typedef enum int unsigned {
    LINE_SDA = 0,
    LINE_SCL = 1,
    LINE_ENA = 2
  } tw_line_e;
endpackage

// File: rtl/tw_line_sync.sv
`timescale 1ns/1ps
module tw_line_sync #(
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] level_o,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [DEPTH-1:0] chain_q;
    logic [DEPTH-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[DEPTH-2:0], line_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    assign level_o[g] = chain_q[STAGES-1];
    assign rise_o[g]  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[g]  = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/tw_bit_collector.sv
`timescale 1ns/1ps
module tw_bit_collector #(
  parameter int unsigned WORD_BITS = 18,
  parameter int unsigned CNT_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ena_level_i,
  input  logic                 ena_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 sda_i,
  output logic [WORD_BITS-1:0] shreg_o,
  output logic [CNT_W-1:0]     count_o,
  output logic                 exact_o
);
  localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] GOOD_VAL = CNT_W'(WORD_BITS);

  logic [WORD_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 shift_en;
  logic                 cnt_en;

  assign shift_en = scl_fall_i & ena_level_i & ~ena_rise_i;
  assign cnt_en   = ena_rise_i | (shift_en & (cnt_q != SAT_VAL));

  always_comb begin
    sh_d = {sh_q[WORD_BITS-2:0], sda_i};
  end

  always_comb begin
    if (ena_rise_i) cnt_d = '0;
    else            cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign shreg_o = sh_q;
  assign count_o = cnt_q;
  assign exact_o = (cnt_q == GOOD_VAL);

  // R4
  cnt_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_VAL);

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ena_rise_i |=> (cnt_q == '0));

  // R5
  idle_clock_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall_i && !ena_level_i) |=> ($stable(cnt_q) && $stable(sh_q)));
endmodule

// File: rtl/tw_word_latch.sv
`timescale 1ns/1ps
module tw_word_latch #(
  parameter int unsigned DIV_W = 14,
  parameter int unsigned SW_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [DIV_W+SW_W-1:0]   word_i,
  output logic [DIV_W-1:0]        div_o,
  output logic [SW_W-1:0]         sw_o,
  output logic                    zero_o,
  output logic                    valid_o
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [SW_W-1:0]  sw_q, sw_d;
  logic             zero_q, zero_d;
  logic             valid_q;

  always_comb begin
    div_d  = word_i[DIV_W+SW_W-1:SW_W];
    sw_d   = word_i[SW_W-1:0];
    zero_d = (word_i[DIV_W+SW_W-1:SW_W] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sw_q   <= '0;
      zero_q <= 1'b1;
    end else if (load_i) begin
      div_q  <= div_d;
      sw_q   <= sw_d;
      zero_q <= zero_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load_i;
  end

  assign div_o   = div_q;
  assign sw_o    = sw_q;
  assign zero_o  = zero_q;
  assign valid_o = valid_q;

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q == (div_q == '0));
endmodule

// File: rtl/tw_ctrl_rx.sv
`timescale 1ns/1ps
module tw_ctrl_rx
  import tw_ctrl_pkg::*;
#(
  parameter int unsigned DIV_W       = TW_DIV_W,
  parameter int unsigned SW_W        = TW_SW_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sda_i,
  input  logic                    scl_i,
  input  logic                    ena_i,
  output logic [DIV_W-1:0]        div_ratio_o,
  output logic [SW_W-1:0]         switch_o,
  output logic                    pll_disable_o,
  output logic                    word_valid_o,
  output logic [TW_REF_DIV_W-1:0] ref_div_o,
  output logic                    cp_high_o
);
  localparam int unsigned WORD_BITS = DIV_W + SW_W;
  localparam int unsigned CNT_W     = $clog2(WORD_BITS + 2);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [TW_NUM_LINES-1:0] lines, lvl, rise, fall;
  assign lines[LINE_SDA] = sda_i;
  assign lines[LINE_SCL] = scl_i;
  assign lines[LINE_ENA] = ena_i;

  tw_line_sync #(.NUM_LINES(TW_NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_q), .line_i(lines),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  logic [WORD_BITS-1:0] shreg;
  logic [CNT_W-1:0]     count;
  logic                 exact;
  logic                 commit;

  tw_bit_collector #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_collect (
    .clk(clk), .rst_n(rst_sync_q),
    .ena_level_i(lvl[LINE_ENA]), .ena_rise_i(rise[LINE_ENA]),
    .scl_fall_i(fall[LINE_SCL]), .sda_i(lvl[LINE_SDA]),
    .shreg_o(shreg), .count_o(count), .exact_o(exact)
  );

  assign commit = fall[LINE_ENA] & exact;

  tw_word_latch #(.DIV_W(DIV_W), .SW_W(SW_W)) u_latch (
    .clk(clk), .rst_n(rst_sync_q), .load_i(commit), .word_i(shreg),
    .div_o(div_ratio_o), .sw_o(switch_o), .zero_o(pll_disable_o),
    .valid_o(word_valid_o)
  );

  assign ref_div_o = TW_REF_DIV_W'(TW_REF_DIV_VAL);
  assign cp_high_o = 1'b1;

  // R3
  bad_count_keeps_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (fall[LINE_ENA] && (count != CNT_W'(WORD_BITS))) |=>
      ($stable(div_ratio_o) && $stable(switch_o) && !word_valid_o));

  // R2
  good_count_loads_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (fall[LINE_ENA] && (count == CNT_W'(WORD_BITS))) |=>
      (word_valid_o && (div_ratio_o == $past(shreg[WORD_BITS-1:SW_W]))));
endmodule

// File: tb/tw_ctrl_rx_tb_top.sv
`timescale 1ns/1ps
module tw_ctrl_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sda = 1'b0, scl = 1'b0, ena = 1'b0;
  logic [13:0] div_ratio;
  logic [3:0]  sw;
  logic        pll_dis, valid, cp_high;
  logic [9:0]  ref_div;

  int errs = 0;
  int total = 0;
  int valid_seen = 0;

  always #2.5 clk = ~clk;

  tw_ctrl_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sda_i(sda), .scl_i(scl), .ena_i(ena),
    .div_ratio_o(div_ratio), .switch_o(sw), .pll_disable_o(pll_dis),
    .word_valid_o(valid), .ref_div_o(ref_div), .cp_high_o(cp_high)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: line history, edge counter, held word
  int h_sda[4], h_scl[4], h_ena[4];
  int m_cnt, m_sh, m_div, m_sw, m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin h_sda[i] = 0; h_scl[i] = 0; h_ena[i] = 0; end
      m_cnt = 0; m_sh = 0; m_div = 0; m_sw = 0; m_valid = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        h_sda[i] = h_sda[i-1]; h_scl[i] = h_scl[i-1]; h_ena[i] = h_ena[i-1];
      end
      h_sda[0] = int'(sda); h_scl[0] = int'(scl); h_ena[0] = int'(ena);
      m_valid = 0;
      if (h_ena[3] == 0 && h_ena[2] == 1) begin
        m_cnt = 0;
      end else begin
        if (h_ena[3] == 1 && h_ena[2] == 0 && m_cnt == 18) begin
          m_div = (m_sh >> 4) & 16'h3FFF;
          m_sw = m_sh & 4'hF;
          m_valid = 1;
        end
        if (h_scl[3] == 1 && h_scl[2] == 0 && h_ena[2] == 1) begin
          m_sh = ((m_sh << 1) | h_sda[2]) & 18'h3FFFF;
          if (m_cnt < 19) m_cnt++;
        end
      end
    end
  end

  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 model div", int'(div_ratio), m_div);
      chk("R2 model sw", int'(sw), m_sw);
      chk("R7 model pll_disable", int'(pll_dis), (m_div == 0) ? 1 : 0);
      chk("R8 model word_valid", int'(valid), m_valid);
      chk("R9 ref_div", int'(ref_div), 512);
      chk("R9 cp_high", int'(cp_high), 1);
      if (prev_valid && valid) chk("R8 pulse width", 1, 0);
      if (valid) valid_seen++;
      prev_valid = valid;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int nbits, input logic [63:0] pat, input bit take);
    ena = 1'b1;
    wait_n(4);
    for (int i = 0; i < nbits; i++) begin
      sda = pat[nbits-1-i];
      wait_n(2);
      scl = 1'b1;
      wait_n(4);
      scl = 1'b0;
      wait_n(4);
    end
    ena = 1'b0;
    wait_n(2);
    chk("R8 no early valid", int'(valid), 0);
    wait_n(1);
    chk("R8 valid latency", int'(valid), take ? 1 : 0);
    wait_n(6);
  endtask

  task automatic expect_word(input string req, input logic [17:0] w);
    chk(req, int'(div_ratio), int'(w[17:4]));
    chk(req, int'(sw), int'(w[3:0]));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait_n(4);
    // R1
    chk("R1 reset div", int'(div_ratio), 0);
    chk("R1 reset sw", int'(sw), 0);
    chk("R1 reset valid", int'(valid), 0);
    chk("R1 reset pll_disable", int'(pll_dis), 1);
    // R2 exact frame
    send_frame(18, 64'h2A5C3, 1'b1);
    expect_word("R2 word A", 18'h2A5C3);
    chk("R7 nonzero", int'(pll_dis), 0);
    // R3 short frame
    send_frame(17, 64'h1FFFF, 1'b0);
    expect_word("R3 short kept", 18'h2A5C3);
    // R4 long frames
    send_frame(19, 64'h7FFFF, 1'b0);
    expect_word("R4 19 kept", 18'h2A5C3);
    send_frame(50, 64'h3_1234_5678_9ABC, 1'b0);
    expect_word("R4 50 kept", 18'h2A5C3);
    // R5 bus clock edges while enable low
    sda = 1'b1;
    for (int k = 0; k < 6; k++) begin
      scl = 1'b1; wait_n(4); scl = 1'b0; wait_n(4);
    end
    wait_n(4);
    expect_word("R5 idle edges", 18'h2A5C3);
    send_frame(18, 64'h1B3E9, 1'b1);
    expect_word("R5 frame after idle", 18'h1B3E9);
    // R6 short then exact
    send_frame(10, 64'h3FF, 1'b0);
    send_frame(18, 64'h0C71E, 1'b1);
    expect_word("R6 after short", 18'h0C71E);
    // R7 zero divider
    send_frame(18, 64'h0000A, 1'b1);
    expect_word("R7 zero word", 18'h0000A);
    chk("R7 pll_disable set", int'(pll_dis), 1);
    send_frame(18, 64'h00010, 1'b1);
    chk("R7 pll_disable clear", int'(pll_dis), 0);
    // R8 pulse count
    chk("R8 valid pulses", valid_seen, 5);
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    total++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule